// File: doc/BRIEF.md
# Sparse Carry-Tree Adder

This block adds two unsigned WIDTH-bit operands and a single carry input. It returns a WIDTH-bit sum and a carry output, all in one combinational pass with no storage. The adder is cut into 4-bit segments. Each segment reduces its bits to one group generate/propagate pair. A logarithmic prefix network, in which every node at a level merges with the node a power-of-two distance below it, combines those pairs. It yields the carry into every segment. A final row of generate-only cells folds in the external carry. Inside each segment, a short ripple chain starts from the carry that the tree delivers and forms the sum bits.

The block is meant to be placed wherever a wide single-cycle addition sits on a timing-critical path. Typical uses are address generation or an accumulator feed. Operand width and segment width are parameters. Elaboration rejects any width that is not a power of two made of at least two whole segments.

Top module: `spa_adder`

## Requirements
- R1: For every pair of operands and carry input, {c_out, sum_out} equals the (WIDTH+1)-bit arithmetic value a_in + b_in + c_in.
- R2: With both operands zero, sum_out equals c_in zero-extended and c_out is 0.
- R3: An all-ones operand plus an operand of value 1, with c_in at 0, gives a zero sum and c_out at 1.
- R4: An all-ones operand plus a zero operand, with c_in at 1, gives a zero sum and c_out at 1. The input carry has to pass through every segment boundary.
- R5: When a_in XOR b_in is all ones, sum_out is all ones and c_out is 0 if c_in is 0. Sum_out is zero and c_out is 1 if c_in is 1. Complementary alternating patterns such as 0101... and 1010... are one such case.
- R6: The carry entering segment k, which covers bits 4k+3 down to 4k, equals bit 4k of the sum of the operand bits below 4k plus c_in. A carry generated in the top bit of one segment appears as a set low bit of the next segment.
- R7: Both operands all ones with c_in at 1 give an all-ones sum with c_out at 1.
- R8: A 64-bit instance meets R1 through R7 the same way the 32-bit instance does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First addend |
| b_in | input | WIDTH | Second addend |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Low WIDTH bits of the sum |
| c_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that has to cross many segment boundaries. That needs every group below the point of interest to be in pure propagate state. Uniform random operands almost never produce this. The stimulus therefore mixes plain random operands with vectors where b_in is the bitwise complement of a_in, which makes the whole word propagate. It also uses that complement with one random bit flipped, which plants a single generate or kill at an arbitrary position. Directed vectors add a generate at the top bit of each segment in turn, so that every tree output is exercised on its own.

// File: rtl/spa_pkg.sv
package spa_pkg;

   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // Prefix operator: hi covers the upper span, lo the span just below it.
   function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (hi.p & lo.g);
      r.p = hi.p & lo.p;
      return r;
   endfunction

   function automatic logic is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/spa_gp_pre.sv
module spa_gp_pre
   import spa_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output gp_t  [WIDTH-1:0] bit_gp
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_gp[i].g = opa[i] & opb[i];
      assign bit_gp[i].p = opa[i] ^ opb[i];
   end

endmodule

// File: rtl/spa_seg_gp.sv
module spa_seg_gp
   import spa_pkg::*;
#(
   parameter int SEG_W = 4
) (
   input  gp_t [SEG_W-1:0] bit_gp,
   output gp_t             grp_gp
);

   gp_t [SEG_W-1:0] chain;

   assign chain[0] = bit_gp[0];
   for (genvar i = 1; i < SEG_W; i++) begin : g_chain
      assign chain[i] = gp_join(bit_gp[i], chain[i-1]);
   end

   assign grp_gp = chain[SEG_W-1];

endmodule

// File: rtl/spa_rca_seg.sv
module spa_rca_seg
   import spa_pkg::*;
#(
   parameter int SEG_W = 4
) (
   input  gp_t  [SEG_W-1:0] bit_gp,
   input  logic             c_seg,
   output logic [SEG_W-1:0] sum
);

   logic [SEG_W-1:0] c;

   assign c[0] = c_seg;
   for (genvar i = 0; i < SEG_W; i++) begin : g_rip
      assign sum[i] = bit_gp[i].p ^ c[i];
      if (i < SEG_W - 1) begin : g_next
         assign c[i+1] = bit_gp[i].g | (bit_gp[i].p & c[i]);
      end
   end

endmodule

// File: rtl/spa_ks_tree.sv
module spa_ks_tree
   import spa_pkg::*;
#(
   parameter int NODES = 8
) (
   input  gp_t  [NODES-1:0] leaf,
   input  logic             c_in,
   output logic [NODES-1:0] carry
);

   localparam int LEVELS = $clog2(NODES);

   gp_t [NODES-1:0] stg [LEVELS+1];

   assign stg[0] = leaf;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int SPAN = 1 << l;
      for (genvar j = 0; j < NODES; j++) begin : g_node
         if (j >= SPAN) begin : g_black
            assign stg[l+1][j] = gp_join(stg[l][j], stg[l][j-SPAN]);
         end else begin : g_pass
            assign stg[l+1][j] = stg[l][j];
         end
      end
   end

   // Generate-only row: merge each full-span prefix with the carry input.
   for (genvar j = 0; j < NODES; j++) begin : g_gray
      assign carry[j] = stg[LEVELS][j].g | (stg[LEVELS][j].p & c_in);
   end

endmodule

// File: rtl/spa_adder.sv
module spa_adder
   import spa_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SEG_W = 4
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             c_out
);

   localparam int SEGS = WIDTH / SEG_W;

   if ((WIDTH % SEG_W) != 0 || !is_pow2(WIDTH) || !is_pow2(SEG_W) || SEGS < 2) begin : g_bad_cfg
      $error("spa_adder: WIDTH must be a power of two holding at least two SEG_W segments");
   end

   gp_t  [WIDTH-1:0] bit_gp;
   gp_t  [SEGS-1:0]  grp_gp;
   logic [SEGS-1:0]  grp_carry;
   logic [SEGS-1:0]  seg_cin;

   spa_gp_pre #(.WIDTH(WIDTH)) u_pre (
      .opa    (a_in),
      .opb    (b_in),
      .bit_gp (bit_gp)
   );

   for (genvar s = 0; s < SEGS; s++) begin : g_seg
      spa_seg_gp #(.SEG_W(SEG_W)) u_grp (
         .bit_gp (bit_gp[s*SEG_W +: SEG_W]),
         .grp_gp (grp_gp[s])
      );
      spa_rca_seg #(.SEG_W(SEG_W)) u_rca (
         .bit_gp (bit_gp[s*SEG_W +: SEG_W]),
         .c_seg  (seg_cin[s]),
         .sum    (sum_out[s*SEG_W +: SEG_W])
      );
   end

   spa_ks_tree #(.NODES(SEGS)) u_tree (
      .leaf  (grp_gp),
      .c_in  (c_in),
      .carry (grp_carry)
   );

   assign seg_cin = {grp_carry[SEGS-2:0], c_in};
   assign c_out   = grp_carry[SEGS-1];

endmodule

// File: rtl/spa_adder_chk.sv
module spa_adder_chk #(
   parameter int WIDTH = 32,
   parameter int SEG_W = 4
) (
   input logic [WIDTH-1:0]       a_in,
   input logic [WIDTH-1:0]       b_in,
   input logic                   c_in,
   input logic [WIDTH-1:0]       sum_out,
   input logic                   c_out,
   input logic [WIDTH/SEG_W-1:0] seg_cin
);

   localparam int SEGS = WIDTH / SEG_W;

   logic [WIDTH:0] ref_sum;
   assign ref_sum = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};

   always_comb begin
      assert_sum_exact_R1: assert ({c_out, sum_out} == ref_sum)
         else $error("R1: adder result differs from arithmetic sum");
   end

   always_comb begin : seg_link
      logic [WIDTH:0] msk;
      logic [WIDTH:0] lo_sum;
      for (int k = 1; k < SEGS; k++) begin
         msk    = ({{WIDTH{1'b0}}, 1'b1} << (k * SEG_W)) - {{WIDTH{1'b0}}, 1'b1};
         lo_sum = ({1'b0, a_in} & msk) + ({1'b0, b_in} & msk) + {{WIDTH{1'b0}}, c_in};
         assert_seg_carry_R6: assert (seg_cin[k] == lo_sum[k*SEG_W])
            else $error("R6: tree carry into a segment is wrong");
      end
   end

   always_comb begin
      if (a_in == '0 && b_in == '0) begin
         assert_zero_ops_R2: assert (sum_out == {{(WIDTH-1){1'b0}}, c_in} && !c_out)
            else $error("R2: zero operands misbehave");
      end
   end

   always_comb begin
      if ((a_in ^ b_in) == '1) begin
         assert_full_prop_R5: assert (c_out == c_in && sum_out == {WIDTH{~c_in}})
            else $error("R5: full-propagate word misbehaves");
      end
   end

   always_comb begin
      if (a_in == '1 && b_in == '1) begin
         assert_max_ops_R7: assert (c_out && sum_out == {{(WIDTH-1){1'b1}}, c_in})
            else $error("R7: maximum operands misbehave");
      end
   end

endmodule

bind spa_adder spa_adder_chk #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_chk (
   .a_in    (a_in),
   .b_in    (b_in),
   .c_in    (c_in),
   .sum_out (sum_out),
   .c_out   (c_out),
   .seg_cin (seg_cin)
);

// File: tb/spa_adder_tb.sv
module spa_adder_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [31:0] a32, b32, s32;
   logic        ci32, co32;
   logic [63:0] a64, b64, s64;
   logic        ci64, co64;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   spa_adder #(.WIDTH(32), .SEG_W(4)) u_dut (
      .a_in (a32), .b_in (b32), .c_in (ci32), .sum_out (s32), .c_out (co32)
   );

   spa_adder #(.WIDTH(64), .SEG_W(4)) u_dut64 (
      .a_in (a64), .b_in (b64), .c_in (ci64), .sum_out (s64), .c_out (co64)
   );

   function automatic logic [32:0] model32(input logic [31:0] x, input logic [31:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {32'd0, c};
   endfunction

   function automatic logic [64:0] model64(input logic [63:0] x, input logic [63:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {64'd0, c};
   endfunction

   task automatic chk32(input logic [31:0] x, input logic [31:0] y, input logic c, input string tag);
      logic [32:0] exp;
      @(negedge clk);
      a32 = x; b32 = y; ci32 = c;
      @(posedge clk);
      #2;
      exp = model32(x, y, c);
      n_chk++;
      if ({co32, s32} !== exp) begin
         n_err++;
         $display("FAIL %s w32 a=%h b=%h c=%b got=%h exp=%h", tag, x, y, c, {co32, s32}, exp);
      end
   endtask

   task automatic chk64(input logic [63:0] x, input logic [63:0] y, input logic c, input string tag);
      logic [64:0] exp;
      @(negedge clk);
      a64 = x; b64 = y; ci64 = c;
      @(posedge clk);
      #2;
      exp = model64(x, y, c);
      n_chk++;
      if ({co64, s64} !== exp) begin
         n_err++;
         $display("FAIL %s w64 a=%h b=%h c=%b got=%h exp=%h", tag, x, y, c, {co64, s64}, exp);
      end
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      a32 = '0; b32 = '0; ci32 = 1'b0;
      a64 = '0; b64 = '0; ci64 = 1'b0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      #2;
      n_chk++;
      if ({co32, s32} !== 33'd0 || {co64, s64} !== 65'd0) begin
         n_err++;
         $display("FAIL R2 idle got32=%h got64=%h exp=0", {co32, s32}, {co64, s64});
      end
      rst = 1'b0;

      // R2 zero operands, carry in cleared and set
      chk32('0, '0, 1'b0, "R2");
      chk32('0, '0, 1'b1, "R2");
      chk64('0, '0, 1'b1, "R2");
      // R3 all ones plus one
      chk32('1, 32'd1, 1'b0, "R3");
      chk64(64'd1, '1, 1'b0, "R3");
      // R4 carry in rippling through every boundary
      chk32('1, '0, 1'b1, "R4");
      chk64('0, '1, 1'b1, "R4");
      // R5 alternating complementary patterns and same-pattern doubling
      chk32(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R5");
      chk32(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R5");
      chk32(32'h5555_5555, 32'h5555_5555, 1'b1, "R5");
      chk64({2{32'hAAAA_AAAA}}, {2{32'h5555_5555}}, 1'b1, "R5");
      chk64({2{32'hAAAA_AAAA}}, {2{32'hAAAA_AAAA}}, 1'b0, "R5");
      // R7 maximum operands
      chk32('1, '1, 1'b1, "R7");
      chk64('1, '1, 1'b1, "R7");
      // R6 generate at the top bit of each segment
      for (int k = 0; k < 8; k++) begin
         chk32(32'd1 << (4*k+3), 32'd1 << (4*k+3), 1'b0, "R6");
         chk32(32'hF << (4*k), 32'd1 << (4*k), 1'b0, "R6");
      end
      for (int k = 0; k < 16; k++) begin
         chk64(64'd1 << (4*k+3), 64'd1 << (4*k+3), 1'b1, "R6");
      end
      // R1 / R8 random mix with propagate-heavy shaping
      for (int n = 0; n < 400; n++) begin
         logic [31:0] x;
         logic [31:0] y;
         int mode;
         x = $urandom();
         mode = int'($urandom() % 4);
         case (mode)
            0: y = $urandom();
            1: y = ~x;
            2: y = ~x ^ (32'd1 << ($urandom() % 32));
            default: y = ~x & ~(32'hF << (4 * ($urandom() % 8)));
         endcase
         chk32(x, y, 1'($urandom()), "R1");
      end
      for (int n = 0; n < 400; n++) begin
         logic [63:0] x;
         logic [63:0] y;
         int mode;
         x = rnd64();
         mode = int'($urandom() % 4);
         case (mode)
            0: y = rnd64();
            1: y = ~x;
            2: y = ~x ^ (64'd1 << ($urandom() % 64));
            default: y = ~x & ~(64'hF << (4 * ($urandom() % 16)));
         endcase
         chk64(x, y, 1'($urandom()), "R8");
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired got=running exp=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule